// File: doc/BRIEF.md
# Line-21 Caption Waveform Inserter

This block produces the digital luminance waveform that carries caption or extended-data bytes on one chosen line of every field. On that line it emits seven cycles of a clock-like run-in, a three-bit framing pattern, and then sixteen data bits taken from a two-byte pair. All of it is timed at 32 bit periods per line. A separate byte pair and a separate enable exist for each of the two fields.

The line timing generator supplies a pixel clock enable, a start-of-line pulse, the line number within the field, and the field identity. The block derives a half-bit tick from the pixel count with a fractional accumulator. Because of this, exactly 64 half periods fit in a line for both the 60 Hz and 50 Hz line lengths. While the caption window is open, `cc_active` tells the downstream mixer to replace normal video with `cc_level`. Low bits are sent at the black (0 IRE) code and high bits at roughly 50 IRE.

Top module: `cc21_line21_enc`

## Requirements
- R1: While reset is applied and after it is released, before any line start, `cc_active` is 0 and `cc_level` equals the low code.
- R2: The override happens only on the line whose number equals BASE_LINE (21) plus `line_sel`. On every other line `cc_active` stays 0.
- R3: A line start (taken when `line_start` and `pix_ce` are both high) resets the half-bit index to 0. After p further enabled pixels, the index is min(63, floor(64·p/L)). L is 780 when `std_50`=0 and 944 when `std_50`=1, so a line holds 32 bit periods.
- R4: The window opens at half index START_HALF (8). The first 14 halves of the window are the run-in: high on even halves, low on odd halves, which gives 7 cycles.
- R5: The next 6 halves are the framing code: two low bit periods followed by one high bit period.
- R6: The last 32 halves carry 16 data bits, two halves per bit. The order is bit 0 first of byte [7:0], then bit 0 first of byte [15:8]. Bit 7 of each byte is sent exactly as supplied.
- R7: The low level is code 64 and the high level is code 502 on the 10-bit output. No other value appears.
- R8: Field 0 (`field_id`=0) uses `pair_f0` and `cap_en[0]`. Field 1 uses `pair_f1` and `cap_en[1]`.
- R9: When the selected field's enable is 0, the window is still overridden (`cc_active`=1), but only at the low level.
- R10: The byte pair and enable are captured at the line start. Changes during the line have no effect on that line's waveform.
- R11: On the caption line, outside the 52-half window, `cc_active` is 0 and `cc_level` is the low code.
- R12: When `pix_ce` is low, the outputs and the internal timing hold their values.
- R13: The outputs are registered. The value after an enabled edge reflects the half index held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| line_start | input | 1 | First pixel of a line (qualified by pix_ce) |
| line_num | input | LINE_W | Line number within the current field |
| field_id | input | 1 | Field identity, 0 or 1 |
| std_50 | input | 1 | 1 selects the 50 Hz line length |
| line_sel | input | SEL_W | Caption line offset above BASE_LINE |
| cap_en | input | 2 | Per-field caption enable |
| pair_f0 | input | 16 | Byte pair for field 0, first byte in [7:0] |
| pair_f1 | input | 16 | Byte pair for field 1, first byte in [7:0] |
| cc_active | output | 1 | Override normal video with cc_level |
| cc_level | output | LVL_W | Luminance code during override |

## Verification
A wrong accumulator or half index shifts bit edges within a few half periods. Over one line it also stretches or squeezes the 52-half window, so the per-pixel comparison on the caption line shows it within that line. A wrong latch of the line hit or field shows up immediately as `cc_active` on the wrong line, or as the other field's bytes, at the first window half. A stale or wrongly ordered data register appears as a wrong level in the first data bit period that differs. Stalling `pix_ce` makes any state that advances without the enable visible as drift in the same line.

// File: rtl/cc21_pkg.sv
package cc21_pkg;
  localparam int HALVES_PER_LINE = 64;
  localparam int RUNIN_HALVES    = 14;
  localparam int FRAME_HALVES    = 6;
  localparam int DATA_HALVES     = 32;
  localparam int WINDOW_HALVES   = RUNIN_HALVES + FRAME_HALVES + DATA_HALVES;
  localparam int PAIR_W          = 16;

  typedef logic [5:0] half_idx_t;

  typedef enum logic [1:0] {
    SEG_OFF,
    SEG_RUNIN,
    SEG_FRAME,
    SEG_DATA
  } seg_e;
endpackage

// File: rtl/cc21_half_clock.sv
module cc21_half_clock
  import cc21_pkg::*;
#(
  parameter int LEN_60 = 780,
  parameter int LEN_50 = 944
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pix_ce,
  input  logic      line_start,
  input  logic      std_50,
  output half_idx_t half_idx
);
  localparam int LEN_MAX = (LEN_60 > LEN_50) ? LEN_60 : LEN_50;
  localparam int AW      = $clog2(LEN_MAX + HALVES_PER_LINE) + 1;

  logic [AW-1:0] acc_q, acc_d, sum, len_sel;
  half_idx_t     half_q, half_d;

  always_comb begin
    len_sel = std_50 ? AW'(LEN_50) : AW'(LEN_60);
    sum     = acc_q + AW'(HALVES_PER_LINE);
    acc_d   = acc_q;
    half_d  = half_q;
    if (line_start) begin
      acc_d  = '0;
      half_d = '0;
    end else if (sum >= len_sel) begin
      acc_d = sum - len_sel;
      if (half_q != '1) half_d = half_q + 6'd1;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      half_q <= '1;
    end else if (pix_ce) begin
      acc_q  <= acc_d;
      half_q <= half_d;
    end
  end

  assign half_idx = half_q;

  // R3
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !line_start) |=> (half_q == $past(half_q) || half_q == $past(half_q) + 6'd1));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> ($stable(half_q) && $stable(acc_q)));
endmodule

// File: rtl/cc21_line_latch.sv
module cc21_line_latch
  import cc21_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int SEL_W     = 3,
  parameter int BASE_LINE = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic [SEL_W-1:0]  line_sel,
  input  logic [1:0]        cap_en,
  input  logic [PAIR_W-1:0] pair_f0,
  input  logic [PAIR_W-1:0] pair_f1,
  output logic              hit_q,
  output logic              en_q,
  output logic [PAIR_W-1:0] data_q
);
  logic [LINE_W-1:0] target;
  logic              hit_d, en_d, take;
  logic [PAIR_W-1:0] data_d;

  always_comb begin
    target = LINE_W'(BASE_LINE) + LINE_W'(line_sel);
    take   = pix_ce && line_start;
    hit_d  = hit_q;
    en_d   = en_q;
    data_d = data_q;
    if (take) begin
      hit_d  = (line_num == target);
      en_d   = cap_en[field_id];
      data_d = field_id ? pair_f1 : pair_f0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      hit_q  <= hit_d;
      en_q   <= en_d;
      data_q <= data_d;
    end
  end

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ce && line_start) |=> ($stable(data_q) && $stable(en_q) && $stable(hit_q)));
endmodule

// File: rtl/cc21_wave_gen.sv
module cc21_wave_gen
  import cc21_pkg::*;
#(
  parameter int START_HALF = 8,
  parameter int LVL_W      = 10,
  parameter int LVL_LOW    = 64,
  parameter int LVL_HIGH   = 502
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  half_idx_t         half_idx,
  input  logic              hit_q,
  input  logic              en_q,
  input  logic [PAIR_W-1:0] data_q,
  output logic              cc_active,
  output logic [LVL_W-1:0]  cc_level
);
  localparam logic [6:0] END_RUNIN = 7'(RUNIN_HALVES);
  localparam logic [6:0] END_FRAME = 7'(RUNIN_HALVES + FRAME_HALVES);
  localparam logic [6:0] END_WIN   = 7'(WINDOW_HALVES);
  localparam logic [6:0] STOP_BIT  = 7'(RUNIN_HALVES + FRAME_HALVES - 2);

  logic [6:0]       rel, dat_rel;
  logic [3:0]       dat_idx;
  seg_e             seg;
  logic             bit_hi, act_d;
  logic [LVL_W-1:0] lvl_d;
  logic             act_q;
  logic [LVL_W-1:0] lvl_q;

  always_comb begin
    rel     = {1'b0, half_idx} - 7'(START_HALF);
    dat_rel = rel - END_FRAME;
    dat_idx = dat_rel[4:1];
    if (rel < END_RUNIN)      seg = SEG_RUNIN;
    else if (rel < END_FRAME) seg = SEG_FRAME;
    else if (rel < END_WIN)   seg = SEG_DATA;
    else                      seg = SEG_OFF;
    case (seg)
      SEG_RUNIN: bit_hi = ~rel[0];
      SEG_FRAME: bit_hi = (rel >= STOP_BIT);
      SEG_DATA:  bit_hi = data_q[dat_idx];
      default:   bit_hi = 1'b0;
    endcase
    act_d = hit_q && (seg != SEG_OFF);
    lvl_d = (act_d && en_q && bit_hi) ? LVL_W'(LVL_HIGH) : LVL_W'(LVL_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lvl_q <= LVL_W'(LVL_LOW);
    end else if (pix_ce) begin
      act_q <= act_d;
      lvl_q <= lvl_d;
    end
  end

  assign cc_active = act_q;
  assign cc_level  = lvl_q;

  // R2
  off_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !hit_q) |=> !cc_active);

  // R9
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !en_q) |=> (cc_level == LVL_W'(LVL_LOW)));
endmodule

// File: rtl/cc21_line21_enc.sv
module cc21_line21_enc
  import cc21_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int SEL_W      = 3,
  parameter int BASE_LINE  = 21,
  parameter int LEN_60     = 780,
  parameter int LEN_50     = 944,
  parameter int START_HALF = 8,
  parameter int LVL_W      = 10,
  parameter int LVL_LOW    = 64,
  parameter int LVL_HIGH   = 502
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic              std_50,
  input  logic [SEL_W-1:0]  line_sel,
  input  logic [1:0]        cap_en,
  input  logic [15:0]       pair_f0,
  input  logic [15:0]       pair_f1,
  output logic              cc_active,
  output logic [LVL_W-1:0]  cc_level
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  half_idx_t         half_idx;
  logic              hit_q, en_q;
  logic [PAIR_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cc21_half_clock #(.LEN_60(LEN_60), .LEN_50(LEN_50)) u_half (
    .clk(clk), .rst_n(core_rst_n), .pix_ce(pix_ce), .line_start(line_start),
    .std_50(std_50), .half_idx(half_idx)
  );

  cc21_line_latch #(.LINE_W(LINE_W), .SEL_W(SEL_W), .BASE_LINE(BASE_LINE)) u_latch (
    .clk(clk), .rst_n(core_rst_n), .pix_ce(pix_ce), .line_start(line_start),
    .line_num(line_num), .field_id(field_id), .line_sel(line_sel), .cap_en(cap_en),
    .pair_f0(pair_f0), .pair_f1(pair_f1), .hit_q(hit_q), .en_q(en_q), .data_q(data_q)
  );

  cc21_wave_gen #(.START_HALF(START_HALF), .LVL_W(LVL_W), .LVL_LOW(LVL_LOW),
                  .LVL_HIGH(LVL_HIGH)) u_wave (
    .clk(clk), .rst_n(core_rst_n), .pix_ce(pix_ce), .half_idx(half_idx),
    .hit_q(hit_q), .en_q(en_q), .data_q(data_q),
    .cc_active(cc_active), .cc_level(cc_level)
  );

  // R7
  level_legal_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cc_level == LVL_W'(LVL_LOW) || cc_level == LVL_W'(LVL_HIGH)));

  // R11
  idle_is_low_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cc_active |-> (cc_level == LVL_W'(LVL_LOW)));
endmodule

// File: tb/cc21_line21_enc_tb_top.sv
module cc21_line21_enc_tb_top;
  localparam int LEN60 = 780;
  localparam int LEN50 = 944;
  localparam int SH    = 8;
  localparam int LOWC  = 64;
  localparam int HIGHC = 502;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_ce, line_start, field_id, std_50;
  logic [9:0] line_num;
  logic [2:0] line_sel;
  logic [1:0] cap_en;
  logic [15:0] pair_f0, pair_f1;
  logic       cc_active;
  logic [9:0] cc_level;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cc21_line21_enc dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .line_start(line_start),
    .line_num(line_num), .field_id(field_id), .std_50(std_50), .line_sel(line_sel),
    .cap_en(cap_en), .pair_f0(pair_f0), .pair_f1(pair_f1),
    .cc_active(cc_active), .cc_level(cc_level)
  );

  function automatic void model(input int h, input bit hit, input bit en,
                                input logic [15:0] d, output bit act, output logic [9:0] lvl);
    int rel;
    bit hi;
    rel = h - SH;
    act = hit && rel >= 0 && rel < 52;
    if (rel < 14)      hi = (rel % 2 == 0);
    else if (rel < 20) hi = (rel >= 18);
    else if (rel < 52) hi = d[(rel - 20) / 2];
    else               hi = 1'b0;
    lvl = (act && en && hi) ? 10'(HIGHC) : 10'(LOWC);
  endfunction

  function automatic string seg_req(input int h, input bit hit);
    int rel;
    rel = h - SH;
    if (!hit) return "R2";
    if (rel < 0 || rel >= 52) return "R11";
    if (rel < 14) return "R4";
    if (rel < 20) return "R5";
    return "R6";
  endfunction

  task automatic run_line(input bit fld, input int lnum, input bit s50, input int sel,
                          input bit [1:0] en, input logic [15:0] p0, input logic [15:0] p1,
                          input bit stall, input bit mutate, input string tag);
    int len, p, edges, cyc, bad, h, bad_h;
    bit hit, e, valid, ea, ce, ls, b_act;
    logic [9:0] el, b_lvl, b_exp;
    bit b_eact;
    logic [15:0] d;
    len = s50 ? LEN50 : LEN60;
    hit = (lnum == 21 + sel);
    d = fld ? p1 : p0;
    e = en[fld];
    p = 0; edges = 0; cyc = 0; bad = 0; valid = 0; bad_h = 0;
    ea = 0; el = 10'(LOWC); b_act = 0; b_lvl = 0; b_exp = 0; b_eact = 0;
    while (edges < len) begin
      @(negedge clk);
      if (valid && (cc_active !== ea || cc_level !== el)) begin
        if (bad == 0) begin
          b_act = cc_active; b_lvl = cc_level; b_eact = ea; b_exp = el;
          bad_h = (64 * (p - 1)) / len;
          if (bad_h > 63) bad_h = 63;
        end
        bad++;
      end
      ls = (edges == 0);
      ce = ls || !stall || (cyc % 3 != 1);
      cyc++;
      field_id = fld; line_num = 10'(lnum); std_50 = s50; line_sel = 3'(sel);
      if (ls) begin pair_f0 = p0; pair_f1 = p1; cap_en = en; end
      if (mutate && p == 300) begin pair_f0 = ~p0; pair_f1 = ~p1; cap_en = ~en; end
      pix_ce = ce; line_start = ls;
      if (ce) begin
        if (ls) begin
          valid = 0; p = 0;
        end else begin
          h = (64 * p) / len;
          if (h > 63) h = 63;
          model(h, hit, e, d, ea, el);
          valid = 1; p++;
        end
        edges++;
      end
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s/%s half=%0d: got active=%0b level=%0d, expected active=%0b level=%0d (%0d bad samples)",
               tag, seg_req(bad_h, hit), bad_h, b_act, b_lvl, b_eact, b_exp, bad);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (cc_active !== 1'b0) begin
      failures++;
      $display("FAIL R1 active: got %0b expected 0", cc_active);
    end
    checks++;
    if (cc_level !== 10'(LOWC)) begin
      failures++;
      $display("FAIL R1 level: got %0d expected %0d", cc_level, LOWC);
    end
  endtask

  task automatic t_basic();
    run_line(0, 21, 0, 0, 2'b01, 16'hA714, 16'h0000, 0, 0, "R3 R6 R7 R13");
    run_line(0, 21, 0, 0, 2'b01, 16'h80FF, 16'h5555, 0, 0, "R4 R5 R6 R7");
  endtask

  task automatic t_std50();
    run_line(1, 21, 1, 0, 2'b10, 16'h0000, 16'hC3B6, 0, 0, "R3 R8");
  endtask

  task automatic t_field1();
    run_line(1, 21, 0, 0, 2'b10, 16'hFFFF, 16'h2D91, 0, 0, "R8");
  endtask

  task automatic t_disabled();
    run_line(0, 21, 0, 0, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, "R9");
  endtask

  task automatic t_line_sel();
    run_line(0, 20, 0, 0, 2'b11, 16'hFFFF, 16'hFFFF, 0, 0, "R2 miss");
    run_line(0, 24, 0, 3, 2'b11, 16'h6E1B, 16'hFFFF, 0, 0, "R2 offset hit");
    run_line(1, 21, 0, 3, 2'b11, 16'hFFFF, 16'hFFFF, 0, 0, "R2 offset miss");
  endtask

  task automatic t_midline();
    run_line(0, 21, 0, 0, 2'b01, 16'h3C5A, 16'h0000, 0, 1, "R10");
  endtask

  task automatic t_stall();
    run_line(1, 21, 0, 0, 2'b10, 16'h0000, 16'hB2E7, 1, 0, "R12");
    run_line(0, 30, 0, 0, 2'b00, 16'h0000, 16'h0000, 0, 0, "R2 trailing");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_ce = 1'b0; line_start = 1'b0; field_id = 1'b0; std_50 = 1'b0;
    line_num = '0; line_sel = '0; cap_en = '0; pair_f0 = '0; pair_f1 = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    pix_ce = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_basic();
    t_std50();
    t_field1();
    t_disabled();
    t_line_sel();
    t_midline();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule